// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a first-in first-out buffer of 64 words, 4 bits each. It has no read or write enables. A writer raises the `shift_in` strobe to load the word on `din`. A reader lowers the `shift_out` strobe to move past the word on `dout`. The oldest stored word moves to the output stage by itself. Whenever `out_ready` is high, `dout` holds the next unread word.

Both strobes are treated as asynchronous levels. Each passes through a two-flop synchronizer on `clk`, and the block acts on the synchronized edges. Two flags report status: `in_ready` means the block can accept a word, and `out_ready` means `dout` is valid. Two corner cases produce single-cycle flag pulses. One is a word that arrives while `shift_out` is already held high. The other is a write held pending on a full buffer that goes through as soon as a slot frees.

The active-low `rst_n` empties the block at once. If `shift_in` is high when reset is released, the word on `din` is taken in.

Top module: `shift_fifo`

## Requirements
- R1: While `rst_n` is low, and on its release, `in_ready` is 1, `out_ready` is 0 and `dout` is 0, and all stored words are discarded.
- R2: Each high period of `shift_in` captures at most one word from `din`. After the capture, `in_ready` reads 0 until `shift_in` has returned low.
- R3: A word written into an empty buffer appears on `dout`, with `out_ready` high, within 8 clock falling edges after `shift_in` rises. `dout` does not change while `out_ready` stays high.
- R4: Words leave in the order they were written. Once `shift_out` is seen high with `out_ready` high, `out_ready` drops. The output advances to the next word when `shift_out` falls.
- R5: The buffer holds exactly 64 words. A `shift_in` pulse while it is full stores nothing.
- R6: `in_ready` is 0 whenever 64 words are held.
- R7: With the buffer empty, `out_ready` is 0 and `shift_out` pulses have no effect. The last word read stays on `dout` until a new word arrives or reset is applied.
- R8: If `shift_out` is already high when a word reaches an empty output stage, `out_ready` is high for exactly one cycle. That word counts as read when `shift_out` falls.
- R9: If `shift_in` goes high while the buffer is full and stays high, a read gives one single-cycle `in_ready` pulse, and the waiting word is then stored after the older words.
- R10: If `shift_in` is high when `rst_n` is released, the word on `din` is captured. `in_ready` stays 0 until `shift_in` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_in | input | 1 | Write strobe; its rising edge loads `din` |
| din | input | 4 | Word to store; held stable while `shift_in` is high |
| in_ready | output | 1 | High when a new word can be accepted |
| shift_out | input | 1 | Read strobe; its falling edge advances the output |
| dout | output | 4 | Oldest unread word, or the last word read |
| out_ready | output | 1 | High when `dout` holds an unread word |

## Verification
The strobes are exercised in several patterns:
- single isolated writes and reads, which measure the fall-through time and the hold of the last word;
- bursts that fill the buffer and drain it, which separate the 64-word capacity from overflow;
- writes interleaved with reads, which check ordering while the output stage moves;
- `shift_out` held high across an arriving word, and `shift_in` held high across a full-to-not-full change, which bring out the two single-cycle flag pulses;
- reset applied while data is stored and while `shift_in` is held high, which separates a plain clear from a clear followed by capture.

Every word on `dout` is compared with a queue in the bench on each cycle that `out_ready` is high.

// File: rtl/shift_fifo.sv
module shift_fifo #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  output logic [WIDTH-1:0] dout,
  output logic             out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]       si_sync, so_sync;
  logic             si_s, so_s, so_d;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt, cnt_nx, occ_nx, occupancy;
  logic             ov, ov_nx, taken, si_used, si_used_nx;
  logic             cap, adv, load;

  assign si_s = si_sync[1];
  assign so_s = so_sync[1];

  assign cap        = in_ready & si_s & ~si_used;
  assign adv        = so_d & ~so_s & taken;
  assign load       = (~ov | adv) & (cnt != '0);
  assign cnt_nx     = cnt + CW'(cap) - CW'(load);
  assign ov_nx      = load | (ov & ~adv);
  assign occ_nx     = cnt_nx + CW'(ov_nx);
  assign si_used_nx = cap | (si_used & si_s);
  assign occupancy  = cnt + CW'(ov);
  assign out_ready  = ov & ~taken;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (cap) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_sync  <= '0;
      so_sync  <= '0;
      so_d     <= 1'b0;
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      ov       <= 1'b0;
      taken    <= 1'b0;
      si_used  <= 1'b0;
      in_ready <= 1'b1;
      dout     <= '0;
    end else begin
      si_sync  <= {si_sync[0], shift_in};
      so_sync  <= {so_sync[0], shift_out};
      so_d     <= so_s;
      cnt      <= cnt_nx;
      ov       <= ov_nx;
      si_used  <= si_used_nx;
      in_ready <= (occ_nx != CW'(DEPTH)) & ~si_used_nx;
      taken    <= (load | adv) ? 1'b0 : (taken | (ov & so_s));
      if (cap) wptr <= bump(wptr);
      if (load) begin
        dout <= mem[rptr];
        rptr <= bump(rptr);
      end
    end
  end
endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_ready,
  input logic                       out_ready,
  input logic [WIDTH-1:0]           dout,
  input logic                       so_s,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int CW = $clog2(DEPTH + 1);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_ready && dout == '0));

  assert_stable_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && $past(out_ready)) |-> $stable(dout));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH)) |-> !in_ready);

  assert_empty_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !out_ready);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (so_s && $rose(out_ready)) |=> !out_ready);
endmodule

bind shift_fifo shift_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_ready(out_ready),
  .dout(dout), .so_s(so_s), .occ(occupancy)
);

// File: tb/shift_fifo_tb_top.sv
module shift_fifo_tb_top;
  localparam int W = 4;
  localparam int D = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0, shift_in = 1'b0, shift_out = 1'b0;
  logic [W-1:0] din = '0;
  logic         in_ready, out_ready;
  logic [W-1:0] dout;

  shift_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .din(din), .in_ready(in_ready),
    .shift_out(shift_out), .dout(dout), .out_ready(out_ready)
  );

  int total = 0, bad = 0, or_hi = 0, ir_hi = 0, cyc = 0;
  bit mon_en = 0, done = 0;
  logic [W-1:0] q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (out_ready) or_hi++;
    if (in_ready) ir_hi++;
    if (mon_en && out_ready) begin
      if (q.size() == 0) chk(1'b0, "R4 word offered with empty reference", int'(dout), -1);
      else chk(dout == q[0], "R4 per-cycle output compare", int'(dout), int'(q[0]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog R1..all actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [W-1:0] w);
    int g = 0;
    while (!in_ready && g < 300) begin @(negedge clk); g++; end
    chk(in_ready, "R2 ready before write", in_ready, 1);
    din = w; shift_in = 1'b1; q.push_back(w);
    g = 0;
    do begin @(negedge clk); g++; end while (in_ready && g < 300);
    chk(!in_ready, "R2 in_ready low after capture", in_ready, 0);
    nclk(1);
    shift_in = 1'b0;
    nclk(3);
  endtask

  task automatic read();
    int g = 0;
    while (!out_ready && g < 300) begin @(negedge clk); g++; end
    chk(out_ready, "R4 word available", out_ready, 1);
    chk(q.size() > 0 && dout == q[0], "R4 read order", int'(dout), q.size() > 0 ? int'(q[0]) : -1);
    shift_out = 1'b1;
    g = 0;
    while (out_ready && g < 300) begin @(negedge clk); g++; end
    chk(!out_ready, "R4 out_ready drops on shift_out", out_ready, 0);
    shift_out = 1'b0;
    if (q.size() > 0) void'(q.pop_front());
    nclk(4);
  endtask

  initial begin
    nclk(2);
    chk(in_ready && !out_ready && dout == '0, "R1 state in reset", {in_ready, out_ready}, 2);
    rst_n = 1'b1;
    nclk(2);
    chk(in_ready && !out_ready && dout == '0, "R1 state after release", int'(dout), 0);
    mon_en = 1;

    begin
      int g = 0;
      q.push_back(4'h5); din = 4'h5; shift_in = 1'b1;
      while (!out_ready && g < 20) begin @(negedge clk); g++; end
      chk(out_ready && g <= 8, "R3 fall-through latency", g, 8);
      chk(dout == 4'h5, "R3 fall-through data", int'(dout), 5);
      nclk(2);
      chk(!in_ready, "R2 single capture per strobe", in_ready, 0);
      shift_in = 1'b0;
      nclk(4);
      read();
    end

    nclk(6);
    chk(!out_ready && dout == 4'h5, "R7 last word held", int'(dout), 5);
    shift_out = 1'b1; nclk(4); shift_out = 1'b0; nclk(6);
    chk(!out_ready && dout == 4'h5, "R7 empty shift_out ignored", int'(dout), 5);
    write(4'h9); read();

    for (int i = 0; i < 10; i++) write(W'(i * 7 + 3));
    for (int i = 0; i < 10; i++) read();
    write(4'h1); write(4'h2); read(); write(4'h3); read(); read();

    for (int i = 0; i < D; i++) write(W'(i ^ (i >> 2)));
    nclk(6);
    chk(!in_ready, "R6 in_ready low when full", in_ready, 0);
    din = 4'hF; shift_in = 1'b1; nclk(5); shift_in = 1'b0; nclk(6);
    chk(!in_ready, "R6 still full after ignored pulse", in_ready, 0);
    for (int i = 0; i < D; i++) read();
    nclk(10);
    chk(!out_ready, "R5 no word beyond capacity", out_ready, 0);
    chk(q.size() == 0, "R5 reference drained", q.size(), 0);

    for (int i = 0; i < D; i++) write(W'(i + 1));
    nclk(4);
    din = 4'hA; shift_in = 1'b1; q.push_back(4'hA);
    nclk(6);
    chk(!in_ready, "R9 held write waits while full", in_ready, 0);
    ir_hi = 0;
    read();
    nclk(10);
    chk(ir_hi == 1, "R9 in_ready single pulse", ir_hi, 1);
    shift_in = 1'b0; nclk(5);
    chk(!in_ready, "R6 full again after held write", in_ready, 0);
    for (int i = 0; i < D; i++) read();
    nclk(8);
    chk(q.size() == 0 && !out_ready, "R9 held word drained last", q.size(), 0);

    shift_out = 1'b1; nclk(4);
    or_hi = 0;
    write(4'h6);
    nclk(8);
    chk(or_hi == 1, "R8 out_ready single pulse", or_hi, 1);
    shift_out = 1'b0; void'(q.pop_front()); nclk(6);
    chk(!out_ready && dout == 4'h6, "R8 word consumed on fall", int'(dout), 6);
    write(4'h3); read();

    write(4'h7); write(4'h8); write(4'h4);
    nclk(8);
    rst_n = 1'b0; nclk(2);
    chk(in_ready && !out_ready && dout == '0, "R1 reset mid-run", int'(dout), 0);
    q.delete();
    rst_n = 1'b1; nclk(8);
    chk(!out_ready && in_ready, "R1 buffer emptied", out_ready, 0);

    rst_n = 1'b0; din = 4'hC; shift_in = 1'b1; nclk(3);
    q.push_back(4'hC);
    rst_n = 1'b1; nclk(10);
    chk(out_ready && dout == 4'hC, "R10 word captured at release", int'(dout), 12);
    chk(!in_ready, "R10 in_ready low while held", in_ready, 0);
    shift_in = 1'b0; nclk(6);
    chk(in_ready, "R10 in_ready after shift_in falls", in_ready, 1);
    read();
    nclk(6);
    chk(!out_ready, "R10 only one word captured", out_ready, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule